// File: doc/BRIEF.md
# Watchdog Timer with Keyed Clear

This block is a watchdog for a system that must prove it is still alive. A small register file on the bus clock holds a control word (run enable, counter-clock enable, clock source choice, mode, timeout select), accepts clear requests and reports whether the last clear has finished. The counter runs on a separate, slower counter clock. When the count reaches the terminal value picked by the timeout select field, the block raises a one-cycle reset request on the counter clock and starts counting again from zero.

Software keeps the system out of reset by clearing the counter in time. A clear is honoured only when two writes to the clear register arrive back to back: the first carries the opening key, the second the closing key, and both have the clear bit set. Run enable, counter-clock enable and clear all cross into the counter domain through synchronizers and return as acknowledges. Software therefore polls the read-back bits and the clear-done flag instead of trusting its own writes. Only the basic (non-windowed) mode is built.

Top module: `wdg_top`

## Requirements
- R1: After reset the control register reads 0, status bit 0 (clear done) reads 1, `cnt_src_sel` is 0 and `wdt_rst` stays low.
- R2: With run and counter clock enabled and timeout select P (control bits [12:8]), `wdt_rst` pulses for exactly one counter-clock cycle every 2^(P+1) counter-clock cycles.
- R3: A write to address 1 with key bits [15:8] = 0x55 and bit 0 = 1, followed by a write to address 1 with key 0xAA and bit 0 = 1 and no access in between, restarts the counter. Status bit 0 reads 0 in the bus cycle after the second write and returns to 1 once the counter domain has acknowledged.
- R4: A closing write with a wrong key or with bit 0 = 0, or any other register access between the two key writes, abandons the sequence. Status stays 1 and the counter is not cleared.
- R5: Clear writes made while status bit 0 is 0 are ignored: they neither clear the counter nor arm the sequence.
- R6: Control bits 0 (run enable) and 1 (counter-clock enable) read back the acknowledged values. They read 0 right after being written to 1 and take the written value only after the round trip through both synchronizers.
- R7: With run enabled and the counter clock disabled, the counter holds and no reset request is made.
- R8: A control write that changes bit 2 (clock source select) while the counter clock is enabled, or still acknowledged as enabled, is ignored as a whole. With the clock disabled, the change is accepted and appears on `cnt_src_sel`.
- R9: A control write with bit 3 (mode) set is ignored as a whole. Mode always reads 0.
- R10: Every accepted control write restarts the counter and drops status bit 0 until the counter domain acknowledges.
- R11: With run enable 0 the counter stays at zero and no reset request is made.
- R12: A control write made while status bit 0 is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address: 0 control, 1 clear, 2 status |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for `acc_addr` (combinational) |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst_n | input | 1 | Active-low asynchronous reset, counter domain |
| cnt_src_sel | output | 1 | Selected counter clock source, to an external clock mux |
| wdt_rst | output | 1 | Reset request pulse, counter-clock domain |

## Verification
The bench measures the pulse spacing for several timeout selects, from the shortest (two cycles) upward. It does this only after the clear from the control write has been acknowledged, so that a stale prescale or an off-by-one terminal compare would show up as a wrong period. It breaks the key sequence in three ways: wrong closing key, closing clear bit low, and a read between the writes. A tracker that did not reset would clear the counter, and the status flag would drop where it must stay high. It fires key writes and control writes while a clear is still in flight. A design that armed on a pending opening write would accept a lone closing write later, and one that took a pending control write would show the new prescale. It also changes the clock source with the clock running and the counter clock off, and sets the mode bit, checking that the control read-back does not move.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned ADDR_CTRL     = 0;
   localparam int unsigned ADDR_CLR      = 1;
   localparam int unsigned ADDR_STAT     = 2;
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_CEN_BIT  = 1;
   localparam int unsigned CTRL_SEL_BIT  = 2;
   localparam int unsigned CTRL_MODE_BIT = 3;
   localparam int unsigned CTRL_PSEL_LSB = 8;
   localparam int unsigned CLR_GO_BIT    = 0;
   localparam int unsigned CLR_KEY_LSB   = 8;
   localparam int unsigned STAT_DONE_BIT = 0;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdg_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [W-1:0] q_r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q_r <= '0;
               else        q_r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q_r <= '0;
               else        q_r <= g_stage[i-1].q_r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
   import wdg_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter int              ADDR_W    = 2,
   parameter int              PSEL_W    = 5,
   parameter int              KEY_W     = 8,
   parameter logic [KEY_W-1:0] KEY_OPEN  = 'h55,
   parameter logic [KEY_W-1:0] KEY_CLOSE = 'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              en_ack,
   input  logic              cen_ack,
   input  logic              clr_ack,
   output logic              en_q,
   output logic              cen_q,
   output logic              sel_q,
   output logic [PSEL_W-1:0] psel_q,
   output logic              clr_req,
   output logic              armed,
   output logic              cleared
);
   key_state_e   key_st;
   logic         wr_ctrl, wr_clr, ctrl_ok;
   logic         key_first, key_second;
   logic         new_sel, new_mode, clr_go;
   logic [KEY_W-1:0] clr_key;
   logic         unused_bits;

   assign unused_bits = ^acc_wdata;

   assign wr_ctrl  = acc_en && acc_we && (acc_addr == ADDR_W'(ADDR_CTRL));
   assign wr_clr   = acc_en && acc_we && (acc_addr == ADDR_W'(ADDR_CLR));
   assign new_sel  = acc_wdata[CTRL_SEL_BIT];
   assign new_mode = acc_wdata[CTRL_MODE_BIT];
   assign clr_go   = acc_wdata[CLR_GO_BIT];
   assign clr_key  = acc_wdata[CLR_KEY_LSB +: KEY_W];

   assign cleared  = (clr_req == clr_ack);
   assign armed    = (key_st == KEY_ARMED);

   // source may change only with the counter clock fully stopped
   assign ctrl_ok  = wr_ctrl && cleared && !new_mode &&
                     !((new_sel != sel_q) && (cen_ack || cen_q));

   assign key_first  = wr_clr && clr_go && (clr_key == KEY_OPEN) && cleared;
   assign key_second = wr_clr && clr_go && (clr_key == KEY_CLOSE) && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_st <= KEY_IDLE;
      end else if (key_second) begin
         key_st <= KEY_IDLE;
      end else if (key_first) begin
         key_st <= KEY_ARMED;
      end else if (acc_en) begin
         key_st <= KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cen_q  <= 1'b0;
         sel_q  <= 1'b0;
         psel_q <= '0;
      end else if (ctrl_ok) begin
         en_q   <= acc_wdata[CTRL_EN_BIT];
         cen_q  <= acc_wdata[CTRL_CEN_BIT];
         sel_q  <= new_sel;
         psel_q <= acc_wdata[CTRL_PSEL_LSB +: PSEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     clr_req <= 1'b0;
      else if (ctrl_ok || key_second) clr_req <= ~clr_req;
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_addr == ADDR_W'(ADDR_CTRL)) begin
         acc_rdata[CTRL_EN_BIT]                = en_ack;
         acc_rdata[CTRL_CEN_BIT]               = cen_ack;
         acc_rdata[CTRL_SEL_BIT]               = sel_q;
         acc_rdata[CTRL_PSEL_LSB +: PSEL_W]    = psel_q;
      end else if (acc_addr == ADDR_W'(ADDR_STAT)) begin
         acc_rdata[STAT_DONE_BIT]              = cleared;
      end
   end
endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core #(
   parameter int PSEL_W = 5,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              cen_s,
   input  logic              clr_tog_s,
   input  logic [PSEL_W-1:0] psel_in,
   output logic              clr_echo,
   output logic              rst_req,
   output logic [CNT_W-1:0]  cnt_value
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic              tog_d;
   logic              clr_evt;
   logic [PSEL_W-1:0] psel_live;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  term;

   assign clr_evt   = clr_tog_s ^ tog_d;
   assign term      = ALL_ONES >> (CNT_W - 1 - int'(psel_live));
   assign clr_echo  = tog_d;
   assign cnt_value = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_d <= 1'b0;
      else        tog_d <= clr_tog_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         psel_live <= '0;
         rst_req   <= 1'b0;
      end else if (clr_evt) begin
         cnt       <= '0;
         psel_live <= psel_in;
         rst_req   <= 1'b0;
      end else if (!en_s) begin
         cnt       <= '0;
         rst_req   <= 1'b0;
      end else if (!cen_s) begin
         rst_req   <= 1'b0;
      end else if (cnt == term) begin
         cnt       <= '0;
         rst_req   <= 1'b1;
      end else begin
         cnt       <= cnt + CNT_W'(1);
         rst_req   <= 1'b0;
      end
   end
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
   parameter int               DATA_W      = 32,
   parameter int               ADDR_W      = 2,
   parameter int               PSEL_W      = 5,
   parameter int               KEY_W       = 8,
   parameter logic [KEY_W-1:0] KEY_OPEN    = 'h55,
   parameter logic [KEY_W-1:0] KEY_CLOSE   = 'hAA,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              cnt_clk,
   input  logic              cnt_rst_n,
   output logic              cnt_src_sel,
   output logic              wdt_rst
);
   localparam int CNT_W = 1 << PSEL_W;

   generate
      if (PSEL_W < 1 || PSEL_W > 5) begin : g_bad_psel
         $error("wdg_top: PSEL_W must be 1..5");
      end
      if (DATA_W < 8 + PSEL_W || DATA_W < 8 + KEY_W) begin : g_bad_data
         $error("wdg_top: DATA_W too small for the register fields");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wdg_top: ADDR_W must be at least 2");
      end
   endgenerate

   logic              en_q, cen_q, sel_q, clr_req;
   logic [PSEL_W-1:0] psel_q;
   logic              armed, cleared;
   logic              en_s, cen_s, tog_s, clr_echo;
   logic              en_ack, cen_ack, clr_ack;
   logic [CNT_W-1:0]  cnt_value;

   wdg_bus_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSEL_W(PSEL_W), .KEY_W(KEY_W),
      .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
   ) u_regs (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .en_ack(en_ack), .cen_ack(cen_ack), .clr_ack(clr_ack),
      .en_q(en_q), .cen_q(cen_q), .sel_q(sel_q), .psel_q(psel_q),
      .clr_req(clr_req), .armed(armed), .cleared(cleared)
   );

   wdg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_in (
      .clk(cnt_clk), .rst_n(cnt_rst_n),
      .d({en_q, cen_q, clr_req}),
      .q({en_s, cen_s, tog_s})
   );

   wdg_count_core #(.PSEL_W(PSEL_W), .CNT_W(CNT_W)) u_core (
      .clk(cnt_clk), .rst_n(cnt_rst_n),
      .en_s(en_s), .cen_s(cen_s), .clr_tog_s(tog_s), .psel_in(psel_q),
      .clr_echo(clr_echo), .rst_req(wdt_rst), .cnt_value(cnt_value)
   );

   wdg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_back (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .d({en_s, cen_s, clr_echo}),
      .q({en_ack, cen_ack, clr_ack})
   );

   assign cnt_src_sel = sel_q;
endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk
   import wdg_pkg::*;
#(
   parameter int               DATA_W    = 32,
   parameter int               ADDR_W    = 2,
   parameter int               PSEL_W    = 5,
   parameter int               KEY_W     = 8,
   parameter logic [KEY_W-1:0] KEY_OPEN  = 'h55,
   parameter logic [KEY_W-1:0] KEY_CLOSE = 'hAA,
   parameter int               CNT_W     = 32
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              cnt_clk,
   input logic              cnt_rst_n,
   input logic              acc_en,
   input logic              acc_we,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              armed,
   input logic              cleared,
   input logic              en_s,
   input logic [CNT_W-1:0]  cnt_value,
   input logic              wdt_rst
);
   logic clr_wr, go_bit, key_is_open, key_is_close;
   assign clr_wr       = acc_en && acc_we && (acc_addr == ADDR_W'(ADDR_CLR));
   assign go_bit       = acc_wdata[CLR_GO_BIT];
   assign key_is_open  = acc_wdata[CLR_KEY_LSB +: KEY_W] == KEY_OPEN;
   assign key_is_close = acc_wdata[CLR_KEY_LSB +: KEY_W] == KEY_CLOSE;

   // R2: reset request is a single-cycle pulse
   assert_single_pulse_R2: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      wdt_rst |=> !wdt_rst);

   // R11: no request unless the run enable had arrived in the counter domain
   assert_no_rst_when_off_R11: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      wdt_rst |-> $past(en_s));

   // R11: run enable off keeps the count at zero
   assert_cnt_zero_off_R11: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      !en_s |=> (cnt_value == '0));

   // R3: completing the key pair launches a clear
   assert_clear_drops_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (armed && clr_wr && go_bit && key_is_close) |=> !cleared);

   // R5: clear writes while a clear is pending never arm the tracker
   assert_pending_ignored_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!cleared && clr_wr) |=> !armed);

   // R4: any other access while armed drops the sequence
   assert_break_sequence_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (armed && acc_en && !(clr_wr && go_bit && (key_is_open || key_is_close))) |=> !armed);

   // R4: an abandoned sequence leaves the clear state unchanged
   assert_bad_close_no_clear_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (armed && cleared && clr_wr && !(go_bit && key_is_close)) |=> cleared);
endmodule

bind wdg_top wdg_top_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSEL_W(PSEL_W), .KEY_W(KEY_W),
   .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE), .CNT_W(CNT_W)
) u_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
   .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
   .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
   .armed(armed), .cleared(cleared), .en_s(en_s), .cnt_value(cnt_value),
   .wdt_rst(wdt_rst)
);

// File: tb/wdg_top_test.sv
module wdg_top_test;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 2;

   logic              bus_clk = 1'b0;
   logic              cnt_clk = 1'b0;
   logic              bus_rst_n = 1'b0;
   logic              cnt_rst_n = 1'b0;
   logic              acc_en = 1'b0;
   logic              acc_we = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [DATA_W-1:0] acc_wdata = '0;
   logic [DATA_W-1:0] acc_rdata;
   logic              cnt_src_sel;
   logic              wdt_rst;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int pulses = 0;
   int last_stamp = 0;
   int period = 0;

   wdg_top uut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
      .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
      .cnt_src_sel(cnt_src_sel), .wdt_rst(wdt_rst)
   );

   always #10 bus_clk = ~bus_clk;
   always #17 cnt_clk = ~cnt_clk;

   always @(negedge cnt_clk) begin
      cyc++;
      if (wdt_rst) begin
         pulses++;
         period = cyc - last_stamp;
         last_stamp = cyc;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input int addr, input int data);
      @(negedge bus_clk);
      acc_en = 1'b1; acc_we = 1'b1;
      acc_addr = ADDR_W'(addr); acc_wdata = DATA_W'(data);
      @(negedge bus_clk);
      acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic bus_read(input int addr, output int data);
      @(negedge bus_clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_addr = ADDR_W'(addr);
      #2 data = int'(acc_rdata);
      @(negedge bus_clk);
      acc_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic wait_done(input string req);
      int v = 0;
      for (int i = 0; i < 100; i++) begin
         bus_read(2, v);
         if (v[0]) break;
      end
      check(v[0] == 1'b1, req, v & 1, 1);
   endtask

   task automatic key_pair(input int k1, input int g1, input int k2, input int g2);
      bus_write(1, (k1 << 8) | g1);
      bus_write(1, (k2 << 8) | g2);
   endtask

   task automatic wait_pulses(input int target);
      for (int i = 0; i < 20000 && pulses < target; i++) @(negedge bus_clk);
   endtask

   // R1
   task automatic t_reset();
      int v;
      bus_read(0, v); check(v == 0, "R1 ctrl", v, 0);
      bus_read(2, v); check(v == 1, "R1 status", v, 1);
      check(pulses == 0, "R1 no request", pulses, 0);
      check(cnt_src_sel == 1'b0, "R1 src sel", int'(cnt_src_sel), 0);
   endtask

   // R6
   task automatic t_readback();
      int v = 0;
      bus_write(0, 32'h303);
      bus_read(0, v);
      check((v & 3) == 0, "R6 immediate readback", v & 3, 0);
      check(((v >> 8) & 31) == 3, "R6 psel readback", (v >> 8) & 31, 3);
      for (int i = 0; i < 50; i++) begin
         bus_read(0, v);
         if ((v & 3) == 3) break;
      end
      check((v & 3) == 3, "R6 acknowledged", v & 3, 3);
      wait_done("R10 done after ctrl write");
   endtask

   // R2
   task automatic t_timeout(input int p);
      int p0;
      bus_write(0, (p << 8) | 3);
      wait_done("R2 done");
      p0 = pulses;
      wait_pulses(p0 + 2);
      check(pulses >= p0 + 2, "R2 pulses seen", pulses - p0, 2);
      check(period == (2 << p), "R2 period", period, 2 << p);
   endtask

   // R10
   task automatic t_ctrl_restart();
      int p0, v;
      bus_write(0, 32'h603);
      bus_read(2, v);
      check(v == 0, "R10 status drops", v, 0);
      wait_done("R10 done");
      p0 = pulses;
      for (int i = 0; i < 20; i++) begin
         idle(30);
         bus_write(0, 32'h603);
      end
      check(pulses == p0, "R10 rewrites restart count", pulses - p0, 0);
   endtask

   // R3
   task automatic t_key_ok();
      int p0, v;
      bus_write(0, 32'h703);
      wait_done("R3 setup");
      p0 = pulses;
      for (int i = 0; i < 10; i++) begin
         idle(150);
         key_pair(8'h55, 1, 8'hAA, 1);
         bus_read(2, v);
         if (i == 0) check(v == 0, "R3 status drops", v, 0);
      end
      check(pulses == p0, "R3 keyed clears hold off reset", pulses - p0, 0);
      wait_done("R3 status returns");
   endtask

   // R4
   task automatic t_key_bad();
      int p0, v;
      key_pair(8'h55, 1, 8'hA5, 1);
      bus_read(2, v); check(v == 1, "R4 wrong key", v, 1);
      key_pair(8'h55, 1, 8'hAA, 0);
      bus_read(2, v); check(v == 1, "R4 clear bit low", v, 1);
      bus_write(1, (8'h55 << 8) | 1);
      bus_read(0, v);
      bus_write(1, (8'hAA << 8) | 1);
      bus_read(2, v); check(v == 1, "R4 access between writes", v, 1);
      p0 = pulses;
      for (int i = 0; i < 5; i++) begin
         idle(120);
         key_pair(8'h55, 1, 8'hAB, 1);
      end
      check(pulses > p0, "R4 broken clears let timeout fire", pulses - p0, 1);
   endtask

   // R5
   task automatic t_pending();
      int v;
      key_pair(8'h55, 1, 8'hAA, 1);
      bus_write(1, (8'h55 << 8) | 1);
      idle(40);
      bus_write(1, (8'hAA << 8) | 1);
      bus_read(2, v);
      check(v == 1, "R5 pending opening write ignored", v, 1);
   endtask

   // R12
   task automatic t_ctrl_pending();
      int v;
      bus_write(0, 32'h703);
      bus_write(0, 32'h203);
      idle(40);
      bus_read(0, v);
      check(((v >> 8) & 31) == 7, "R12 pending ctrl ignored", (v >> 8) & 31, 7);
   endtask

   // R8
   task automatic t_sel();
      int v = 0;
      bus_write(0, 32'h707);
      idle(40);
      bus_read(0, v);
      check(v == 32'h703, "R8 sel change while running", v, 32'h703);
      check(cnt_src_sel == 1'b0, "R8 src port held", int'(cnt_src_sel), 0);
      bus_write(0, 32'h701);
      for (int i = 0; i < 50; i++) begin
         bus_read(0, v);
         if ((v & 2) == 0) break;
      end
      check((v & 2) == 0, "R6 clock disable acknowledged", v & 2, 0);
      wait_done("R8 done");
      bus_write(0, 32'h705);
      idle(40);
      bus_read(0, v);
      check((v & 4) == 4, "R8 sel accepted when stopped", v & 4, 4);
      check(cnt_src_sel == 1'b1, "R8 src port", int'(cnt_src_sel), 1);
   endtask

   // R7
   task automatic t_cen_stop();
      int p0;
      bus_write(0, 32'h201);
      wait_done("R7 setup");
      idle(10);
      p0 = pulses;
      idle(400);
      check(pulses == p0, "R7 counter clock off", pulses - p0, 0);
      bus_write(0, 32'h203);
      idle(100);
      check(pulses > p0, "R7 counting resumes", pulses - p0, 1);
   endtask

   // R11
   task automatic t_en_off();
      int p0;
      bus_write(0, 32'h202);
      wait_done("R11 setup");
      idle(10);
      p0 = pulses;
      idle(300);
      check(pulses == p0, "R11 run disabled", pulses - p0, 0);
   endtask

   // R9
   task automatic t_mode();
      int v;
      bus_write(0, 32'h50B);
      idle(40);
      bus_read(0, v);
      check(v == 32'h202, "R9 mode write ignored", v, 32'h202);
   endtask

   initial begin
      repeat (150000) @(posedge bus_clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge bus_clk);
      bus_rst_n = 1'b1;
      cnt_rst_n = 1'b1;
      repeat (4) @(negedge bus_clk);
      t_reset();
      t_readback();
      t_timeout(0);
      t_timeout(1);
      t_timeout(3);
      t_timeout(6);
      t_ctrl_restart();
      t_key_ok();
      t_key_bad();
      wait_done("R5 setup");
      t_pending();
      wait_done("R12 setup");
      t_ctrl_pending();
      wait_done("R8 setup");
      t_sel();
      t_cen_stop();
      t_en_off();
      t_mode();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule